// File: doc/BRIEF.md
# DRAM Geometry Probe Engine

This block finds the column width, row width and rank count of an attached DRAM once the data bus width is known. It drives a simple 32-bit memory master port (request, write enable, address, write data, read data, acknowledge) and relies on address aliasing. When an address bit is not decoded by the device, a write to an address with only that bit set lands on the base word. Each candidate size is therefore tested by clearing the base word, writing a fixed pattern at the probe address, and reading both words back.

A one-cycle start pulse launches a run. The run tries columns from the widest candidate down, then rows from the widest down, then tests for a second rank. The bus width input selects how far the column probe addresses are shifted. The results, a done flag and an error code stay on the outputs until the next start pulse. Data-bus-width training and any change to the controller's address map take place outside this block.

Top module: `dram_geom_probe`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `err_o`, `mem_req_o`, `err_kind_o`, `col_bits_o`, `cs0_row_o`, `cs1_row_o` and `rank_o` are all 0.
- R2: Column candidates are tried in the order 11, 10, 9. Each test is four transfers: write 0 to base, write 0x5AA5F00F to base + 2^(col+bw−1), read that probe address, then read base. The first candidate whose probe read returns the pattern while the base read returns 0 is reported on `col_bits_o`.
- R3: `bw_sel_i` is sampled at start. A value of 2 (32-bit bus) places the first column probe at base + 2^12. A value of 1 (16-bit bus) places it at base + 2^11.
- R4: If no column candidate is accepted, the run ends after 12 transfers. It raises `err_o` with `err_kind_o` = 1, and `col_bits_o`, the row outputs and `rank_o` stay 0.
- R5: Row candidates are tried from 16 down to 12 with the probe at base + 2^(row+13), using the same four-transfer test. On success, both `cs0_row_o` and `cs1_row_o` carry the found value.
- R6: If no row candidate is accepted, `err_o` rises with `err_kind_o` = 2 and both row outputs stay 0. Rank detection still runs.
- R7: Rank detection takes five transfers: write 0 to base, write the pattern to base + 2^30, write the inverted pattern to base + 2^30 + 4, read base + 2^30, then read base. `rank_o` is 2 if the first read returns the pattern and the base read returns 0; otherwise `rank_o` is 1.
- R8: A request is held with a stable address, write enable and write data until acknowledged. The next transfer starts only after that acknowledge.
- R9: If a request is not acknowledged within `TIMEOUT_CYC` cycles, the request drops. The run then ends with `err_o` raised and `err_kind_o` = 3.
- R10: A start pulse while busy is ignored. After a run ends, `done_o` and all results hold until the next start, and that start clears `done_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches a probe run |
| bw_sel_i | input | 2 | Bus width code: 2 for 32-bit, 1 for 16-bit |
| mem_req_o | output | 1 | Transfer request, held until acknowledged |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Byte address of the transfer |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Transfer acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held until the next start |
| err_o | output | 1 | Run finished with an error |
| err_kind_o | output | 2 | 0 none, 1 column, 2 row, 3 bus timeout |
| col_bits_o | output | 4 | Detected column bit count |
| cs0_row_o | output | 5 | Detected row bit count, rank 0 |
| cs1_row_o | output | 5 | Detected row bit count, rank 1 |
| rank_o | output | 2 | Detected rank count (1 or 2) |

## Verification
Every transfer costs two cycles of overhead plus the memory's acknowledge latency. A request appears the cycle after the engine issues it, and the next request follows one idle cycle after the acknowledge. `done_o` and the results change on the edge that registers the final acknowledge. The bench therefore waits at falling edges for `done_o` under a cycle limit, instead of predicting a fixed cycle. It then checks every result together with the count of acknowledged transfers, which pins down exactly how many candidates were tried. The timeout case must finish within the watchdog window plus a few cycles. The clear-on-start case is sampled at the first falling edge after the start edge.

// File: rtl/dgp_pkg.sv
package dgp_pkg;

    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] PROBE_PAT = 32'h5AA5_F00F;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_COL  = 2'd1,
        PH_ROW  = 2'd2,
        PH_RANK = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_COL  = 2'd1,
        ERR_ROW  = 2'd2,
        ERR_BUS  = 2'd3
    } err_e;

endpackage

// File: rtl/probe_addr_gen.sv
module probe_addr_gen
    import dgp_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0,
    parameter int          ROW_SHIFT = 13,
    parameter int          RANK_BIT  = 30
) (
    input  phase_e          phase_i,
    input  logic [2:0]      step_i,
    input  logic [4:0]      cand_i,
    input  logic [1:0]      bw_i,
    output logic            we_o,
    output logic [AW-1:0]   addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    localparam int SHW = 6;

    logic [SHW-1:0] shift;
    logic [AW-1:0]  base;
    logic [AW-1:0]  probe;

    assign base = AW'(BASE_ADDR);

    always_comb begin
        unique case (phase_i)
            PH_COL:  shift = {1'b0, cand_i} + {4'b0, bw_i} - SHW'(1);
            PH_ROW:  shift = {1'b0, cand_i} + SHW'(ROW_SHIFT);
            default: shift = SHW'(RANK_BIT);
        endcase
        probe = base + (AW'(1) << shift);
    end

    always_comb begin
        we_o    = 1'b0;
        addr_o  = base;
        wdata_o = '0;
        if (phase_i == PH_RANK) begin
            unique case (step_i)
                3'd0: begin we_o = 1'b1; addr_o = base; wdata_o = '0; end
                3'd1: begin we_o = 1'b1; addr_o = probe; wdata_o = PROBE_PAT; end
                3'd2: begin we_o = 1'b1; addr_o = probe + AW'(4); wdata_o = ~PROBE_PAT; end
                3'd3: begin we_o = 1'b0; addr_o = probe; end
                default: begin we_o = 1'b0; addr_o = base; end
            endcase
        end else begin
            unique case (step_i)
                3'd0: begin we_o = 1'b1; addr_o = base; wdata_o = '0; end
                3'd1: begin we_o = 1'b1; addr_o = probe; wdata_o = PROBE_PAT; end
                3'd2: begin we_o = 1'b0; addr_o = probe; end
                default: begin we_o = 1'b0; addr_o = base; end
            endcase
        end
    end
endmodule

// File: rtl/probe_bus_xfer.sv
module probe_bus_xfer
    import dgp_pkg::*;
#(
    parameter int AW          = 32,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              done_o,
    output logic              timeout_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int WDW = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic              req;
        logic              we;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] wdata;
        logic [WDW-1:0]    wd;
    } xfer_t;

    xfer_t x_d, x_q;

    always_comb begin
        x_d       = x_q;
        done_o    = x_q.req & mem_ack_i;
        timeout_o = x_q.req & ~mem_ack_i & (x_q.wd == WDW'(TIMEOUT_CYC - 1));
        if (start_i && !x_q.req) begin
            x_d.req   = 1'b1;
            x_d.we    = we_i;
            x_d.addr  = addr_i;
            x_d.wdata = wdata_i;
            x_d.wd    = '0;
        end else if (done_o || timeout_o) begin
            x_d.req = 1'b0;
            x_d.wd  = '0;
        end else if (x_q.req) begin
            x_d.wd = x_q.wd + WDW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) x_q <= '0;
        else         x_q <= x_d;
    end

    assign mem_req_o   = x_q.req;
    assign mem_we_o    = x_q.we;
    assign mem_addr_o  = x_q.addr;
    assign mem_wdata_o = x_q.wdata;
    assign rdata_o     = mem_rdata_i;

    // R8
    req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && !mem_ack_i && !timeout_o |=>
            mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o))
        else $error("request changed before acknowledge");

    // R9
    timeout_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |=> !mem_req_o)
        else $error("request still up after timeout");
endmodule

// File: rtl/dram_geom_probe.sv
module dram_geom_probe
    import dgp_pkg::*;
#(
    parameter int          AW          = 32,
    parameter logic [31:0] BASE_ADDR   = 32'h0,
    parameter int          COL_HI      = 11,
    parameter int          COL_LO      = 9,
    parameter int          ROW_HI      = 16,
    parameter int          ROW_LO      = 12,
    parameter int          ROW_SHIFT   = 13,
    parameter int          RANK_BIT    = 30,
    parameter int          TIMEOUT_CYC = 64
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [1:0]    bw_sel_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [31:0]   mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    input  logic          mem_ack_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [1:0]    err_kind_o,
    output logic [3:0]    col_bits_o,
    output logic [4:0]    cs0_row_o,
    output logic [4:0]    cs1_row_o,
    output logic [1:0]    rank_o
);
    localparam logic [2:0] LAST_STD  = 3'd3;
    localparam logic [2:0] LAST_RANK = 3'd4;

    typedef struct packed {
        phase_e     phase;
        logic [2:0] step;
        logic [4:0] cand;
        logic       issued;
        logic       probe_ok;
        logic [1:0] bw;
        logic [3:0] col;
        logic [4:0] row;
        logic [1:0] rank;
        err_e       err;
        logic       done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              xs_start;
    logic              gen_we;
    logic [AW-1:0]     gen_addr;
    logic [DATA_W-1:0] gen_wdata;
    logic              x_done;
    logic              x_timeout;
    logic [DATA_W-1:0] x_rdata;
    logic [AW-1:0]     bus_addr;
    logic [2:0]        last_step;
    logic              hit;

    probe_addr_gen #(
        .AW(AW), .BASE_ADDR(BASE_ADDR), .ROW_SHIFT(ROW_SHIFT), .RANK_BIT(RANK_BIT)
    ) addr_gen_i (
        .phase_i (c_q.phase),
        .step_i  (c_q.step),
        .cand_i  (c_q.cand),
        .bw_i    (c_q.bw),
        .we_o    (gen_we),
        .addr_o  (gen_addr),
        .wdata_o (gen_wdata)
    );

    probe_bus_xfer #(
        .AW(AW), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) xfer_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (xs_start),
        .we_i        (gen_we),
        .addr_i      (gen_addr),
        .wdata_i     (gen_wdata),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (bus_addr),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .mem_ack_i   (mem_ack_i),
        .done_o      (x_done),
        .timeout_o   (x_timeout),
        .rdata_o     (x_rdata)
    );

    assign mem_addr_o = 32'(bus_addr);

    always_comb begin
        c_d       = c_q;
        xs_start  = 1'b0;
        last_step = (c_q.phase == PH_RANK) ? LAST_RANK : LAST_STD;
        hit       = c_q.probe_ok && (x_rdata == '0);
        if (c_q.phase == PH_IDLE) begin
            if (start_i) begin
                c_d.phase    = PH_COL;
                c_d.step     = '0;
                c_d.cand     = 5'(COL_HI);
                c_d.issued   = 1'b0;
                c_d.probe_ok = 1'b0;
                c_d.bw       = bw_sel_i;
                c_d.col      = '0;
                c_d.row      = '0;
                c_d.rank     = '0;
                c_d.err      = ERR_NONE;
                c_d.done     = 1'b0;
            end
        end else if (!c_q.issued) begin
            xs_start   = 1'b1;
            c_d.issued = 1'b1;
        end else if (x_timeout) begin
            c_d.issued = 1'b0;
            c_d.err    = ERR_BUS;
            c_d.done   = 1'b1;
            c_d.phase  = PH_IDLE;
        end else if (x_done) begin
            c_d.issued = 1'b0;
            if (c_q.step == last_step - 3'd1)
                c_d.probe_ok = (x_rdata == PROBE_PAT);
            if (c_q.step != last_step) begin
                c_d.step = c_q.step + 3'd1;
            end else begin
                c_d.step     = '0;
                c_d.probe_ok = 1'b0;
                unique case (c_q.phase)
                    PH_COL: begin
                        if (hit) begin
                            c_d.col   = c_q.cand[3:0];
                            c_d.phase = PH_ROW;
                            c_d.cand  = 5'(ROW_HI);
                        end else if (c_q.cand == 5'(COL_LO)) begin
                            c_d.err   = ERR_COL;
                            c_d.done  = 1'b1;
                            c_d.phase = PH_IDLE;
                        end else begin
                            c_d.cand = c_q.cand - 5'd1;
                        end
                    end
                    PH_ROW: begin
                        if (hit) begin
                            c_d.row   = c_q.cand;
                            c_d.phase = PH_RANK;
                        end else if (c_q.cand == 5'(ROW_LO)) begin
                            c_d.err   = ERR_ROW;
                            c_d.phase = PH_RANK;
                        end else begin
                            c_d.cand = c_q.cand - 5'd1;
                        end
                    end
                    default: begin
                        c_d.rank  = hit ? 2'd2 : 2'd1;
                        c_d.done  = 1'b1;
                        c_d.phase = PH_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign busy_o     = (c_q.phase != PH_IDLE);
    assign done_o     = c_q.done;
    assign err_o      = (c_q.err != ERR_NONE);
    assign err_kind_o = c_q.err;
    assign col_bits_o = c_q.col;
    assign cs0_row_o  = c_q.row;
    assign cs1_row_o  = c_q.row;
    assign rank_o     = c_q.rank;

    // R5
    result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !err_o |->
            (col_bits_o >= 4'(COL_LO)) && (col_bits_o <= 4'(COL_HI)) &&
            (cs0_row_o >= 5'(ROW_LO)) && (cs0_row_o <= 5'(ROW_HI)) &&
            (cs0_row_o == cs1_row_o) && (rank_o != 2'd0))
        else $error("clean result out of range");

    // R4
    col_err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && (err_kind_o == ERR_COL) |-> (rank_o == 2'd0) && !mem_req_o)
        else $error("activity after column failure");

    // R10
    done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !start_i |=> done_o && $stable(col_bits_o) && $stable(rank_o)
                                && $stable(cs0_row_o) && $stable(err_kind_o))
        else $error("result moved without start");

    // R8
    req_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> busy_o)
        else $error("request outside a run");
endmodule

// File: tb/dram_geom_probe_tb.sv
module dram_geom_probe_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  bw_sel_i = 2'd2;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [31:0] mem_rdata_i;
    logic        mem_ack_i;
    logic        busy_o, done_o, err_o;
    logic [1:0]  err_kind_o, rank_o;
    logic [3:0]  col_bits_o;
    logic [4:0]  cs0_row_o, cs1_row_o;

    always #2 clk_i = ~clk_i;

    dram_geom_probe dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .bw_sel_i(bw_sel_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_kind_o(err_kind_o),
        .col_bits_o(col_bits_o), .cs0_row_o(cs0_row_o), .cs1_row_o(cs1_row_o),
        .rank_o(rank_o)
    );

    // memory model: address bits outside dec_mask are not decoded
    logic [31:0] dec_mask = 32'hFFFF_FFFF;
    int          ack_lat = 0;
    logic        stall = 1'b0;
    int unsigned acks = 0;
    int          lat_cnt = 0;
    logic [31:0] ea;
    logic [31:0] store [int unsigned];
    logic [31:0] addr_log [int unsigned];

    always @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mem_ack_i   <= 1'b0;
            mem_rdata_i <= '0;
            lat_cnt     <= 0;
        end else begin
            mem_ack_i <= 1'b0;
            if (mem_req_o && !mem_ack_i && !stall) begin
                if (lat_cnt >= ack_lat) begin
                    lat_cnt   <= 0;
                    mem_ack_i <= 1'b1;
                    ea = mem_addr_o & dec_mask;
                    addr_log[acks] = mem_addr_o;
                    acks = acks + 1;
                    if (mem_we_o) store[ea] = mem_wdata_o;
                    else mem_rdata_i <= store.exists(ea) ? store[ea] : 32'hDEAD_BEEF;
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk_i) cyc <= cyc + 1;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk_i) start_i = 1'b1;
        @(negedge clk_i) start_i = 1'b0;
    endtask

    task automatic wait_done(input int limit, output int used);
        used = 0;
        while (!done_o && used < limit) begin
            @(negedge clk_i);
            used++;
        end
    endtask

    task automatic run(input logic [1:0] bw, input logic [31:0] mask, input int lat,
                       output int unsigned n_xfer, output logic [31:0] first_probe);
        int unsigned b;
        int used;
        bw_sel_i = bw; dec_mask = mask; ack_lat = lat;
        b = acks;
        pulse_start();
        wait_done(5000, used);
        n_xfer = acks - b;
        first_probe = addr_log.exists(b + 1) ? addr_log[b + 1] : 32'hFFFF_FFFF;
    endtask

    task automatic t_reset();
        chk("R1 done", done_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 err", {err_o, err_kind_o}, 0);
        chk("R1 req", mem_req_o, 0);
        chk("R1 results", {col_bits_o, cs0_row_o, cs1_row_o, rank_o}, 0);
    endtask

    task automatic t_wide_bus();
        int unsigned n; logic [31:0] fp;
        run(2'd2, 32'h5FFF_EFFF, 3, n, fp);   // bits 11:0, 28:13, 30
        chk("R2 first probe addr", fp, 32'h0000_1000);
        chk("R2 col", col_bits_o, 10);
        chk("R5 cs0 row", cs0_row_o, 15);
        chk("R5 cs1 row", cs1_row_o, 15);
        chk("R7 rank two", rank_o, 2);
        chk("R8 transfer count", n, 21);
        chk("R2 no error", err_o, 0);
    endtask

    task automatic t_narrow_bus();
        int unsigned n; logic [31:0] fp;
        run(2'd1, 32'h0FFF_E7FF, 0, n, fp);   // bits 10:0, 27:13
        chk("R3 first probe addr", fp, 32'h0000_0800);
        chk("R3 col", col_bits_o, 10);
        chk("R5 row", cs0_row_o, 14);
        chk("R7 rank one", rank_o, 1);
        chk("R3 transfer count", n, 25);
    endtask

    task automatic t_max_geom();
        int unsigned n; logic [31:0] fp;
        run(2'd2, 32'h7FFF_FFFF, 1, n, fp);
        chk("R2 col max", col_bits_o, 11);
        chk("R5 row max", cs1_row_o, 16);
        chk("R7 rank max", rank_o, 2);
        chk("R2 transfer count max", n, 13);
    endtask

    task automatic t_col_fail();
        int unsigned n; logic [31:0] fp;
        run(2'd2, 32'h0000_03FF, 0, n, fp);
        chk("R4 err", err_o, 1);
        chk("R4 kind", err_kind_o, 1);
        chk("R4 transfer count", n, 12);
        chk("R4 results zero", {col_bits_o, cs0_row_o, rank_o}, 0);
        repeat (5) @(negedge clk_i);
        chk("R4 bus quiet", mem_req_o, 0);
    endtask

    task automatic t_row_fail();
        int unsigned n; logic [31:0] fp;
        run(2'd2, 32'h4000_1FFF, 0, n, fp);
        chk("R6 kind", err_kind_o, 2);
        chk("R6 col kept", col_bits_o, 11);
        chk("R6 rows zero", {cs0_row_o, cs1_row_o}, 0);
        chk("R6 rank still found", rank_o, 2);
        chk("R6 transfer count", n, 29);
    endtask

    task automatic t_timeout();
        int used;
        stall = 1'b1;
        pulse_start();
        wait_done(200, used);
        chk("R9 done", done_o, 1);
        chk("R9 kind", err_kind_o, 3);
        chk("R9 req dropped", mem_req_o, 0);
        chk("R9 within window", (used < 80) ? 1 : 0, 1);
        stall = 1'b0;
    endtask

    task automatic t_restart_ignored();
        int unsigned b; int used;
        bw_sel_i = 2'd2; dec_mask = 32'h7FFF_FFFF; ack_lat = 2;
        b = acks;
        pulse_start();
        repeat (10) @(negedge clk_i);
        bw_sel_i = 2'd1;
        pulse_start();
        wait_done(5000, used);
        chk("R10 restart ignored count", acks - b, 13);
        chk("R10 restart ignored col", col_bits_o, 11);
        repeat (8) @(negedge clk_i);
        chk("R10 done held", done_o, 1);
        chk("R10 result held", rank_o, 2);
        @(negedge clk_i) start_i = 1'b1;
        @(negedge clk_i) start_i = 1'b0;
        chk("R10 done cleared", done_o, 0);
        chk("R10 busy again", busy_o, 1);
        wait_done(5000, used);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_wide_bus();
        t_narrow_bus();
        t_max_geom();
        t_col_fail();
        t_row_fail();
        t_timeout();
        t_restart_ignored();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule